// File: doc/BRIEF.md
# Two-Operand ALU with Status Flags

This block is the execution stage for two-operand instructions. It takes a source and a destination operand, an operation code, a width select and the current status flags. One clock edge later it presents a result, a write-back enable and a new four-bit status word. Twelve operations are provided:

- Arithmetic: move, add, add with carry, subtract, subtract with carry, compare, and a packed-BCD add.
- Logic: bit test, bit clear, bit set, exclusive-or and AND.

Every operation runs at one of three widths: 8-bit byte, 16-bit word or 20-bit address. All results and all flags are formed at the selected width.

The flags word is packed as bit 3 = V (overflow), bit 2 = N (negative), bit 1 = Z (zero) and bit 0 = C (carry). Each operation has its own flag rule. A flag is recomputed, forced to a fixed value, or copied unchanged from the incoming flags. Fetching the instruction, addressing the operands, decoding extension words and accessing memory all happen elsewhere. The surrounding pipeline feeds one request per cycle with `in_valid` and takes the registered outputs when `out_valid` is high.

Operation codes: 0 move, 1 add, 2 add with carry, 3 subtract, 4 subtract with carry, 5 compare, 6 decimal add, 7 bit test, 8 bit clear, 9 bit set, 10 exclusive-or, 11 AND. Width codes: 0 byte, 1 word, 2 address, 3 address.

Top module: `alu2op`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `wr_en`, `result` and `flags_out` are all zero.
- R2: The outputs for a request appear one cycle after it. `out_valid` equals `in_valid` of the previous cycle. When no request was presented in that cycle, `wr_en` is low.
- R3: Operands are cut to the selected width before use, and result bits above the width are zero. When N is recomputed it is the top bit at the width (bit 7, 15 or 19). When Z is recomputed it is 1 exactly when the cut result is zero.
- R4: Add (1) and add with carry (2) return dst+src (+C for code 2) at the width. C is the carry out of the top bit, V is the signed overflow, and N and Z follow R3. `wr_en` is 1.
- R5: Subtract (3) returns dst+NOT(src)+1 and subtract with carry (4) returns dst+NOT(src)+C at the width. C is the carry out of the top bit, so C=1 means no borrow. V is the signed overflow. `wr_en` is 1.
- R6: Compare (5) produces the same result and flags as subtract, with `wr_en` 0.
- R7: Decimal add (6) adds packed BCD digits plus the incoming C. Any digit sum above 9 is corrected by adding 6 and carries into the next digit. C is the carry out of the top digit of the width (2, 4 or 5 digits), V is 0, and `wr_en` is 1.
- R8: Bit test (7) and AND (11) return src AND dst with V=0, N and Z per R3, and C = NOT Z. `wr_en` is 0 for bit test and 1 for AND.
- R9: Exclusive-or (10) returns src XOR dst. V is 1 when both cut operands have their top bit set, N and Z follow R3, C = NOT Z, and `wr_en` is 1.
- R10: Move (0) returns src, bit clear (8) returns NOT(src) AND dst, and bit set (9) returns src OR dst. All three write (`wr_en` 1) and pass `flags_in` through unchanged.
- R11: Codes 12 to 15 return result 0 with `wr_en` 0 and pass `flags_in` through unchanged.
- R12: Width code 3 behaves exactly like width code 2 (20-bit).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A request is present this cycle |
| op | input | 4 | Operation code |
| width | input | 2 | Width select: 0 byte, 1 word, 2 or 3 address |
| src | input | 20 | Source operand |
| dst | input | 20 | Destination operand |
| flags_in | input | 4 | Current flags {V,N,Z,C} |
| out_valid | output | 1 | Registered outputs belong to the previous cycle's request |
| result | output | 20 | Result, zero above the selected width |
| wr_en | output | 1 | Destination write-back enable |
| flags_out | output | 4 | Updated flags {V,N,Z,C} |

## Verification
Additions are tried at each width in three cases, and each case separates one thing:

- A sum that crosses only into the sign bit separates overflow from carry.
- A sum that wraps to zero separates carry from overflow and checks Z.
- Operands with bits set above a byte show whether the masking happens before the add.

Subtractions with and without borrow, and with incoming carry 0, show that C means "no borrow" and that the complement-add uses the incoming carry. BCD cases separate a correction inside one digit, a carry rippling through every digit, and where the carry is taken at 16 and 20 bits. Logic and pass-through cases start from flag values opposite to the expected ones, so a flag that is forced, derived from Z or left alone shows up as wrong.

// File: rtl/alu2op.sv
module alu2op (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [3:0]  op,
  input  logic [1:0]  width,
  input  logic [19:0] src,
  input  logic [19:0] dst,
  input  logic [3:0]  flags_in,
  output logic        out_valid,
  output logic [19:0] result,
  output logic        wr_en,
  output logic [3:0]  flags_out
);

  localparam int BYTE_W = 8;
  localparam int WORD_W = 16;
  localparam int ADDR_W = 20;
  localparam int NDIG   = ADDR_W / 4;

  localparam logic [3:0] OP_MOV  = 4'd0;
  localparam logic [3:0] OP_ADD  = 4'd1;
  localparam logic [3:0] OP_ADDC = 4'd2;
  localparam logic [3:0] OP_SUB  = 4'd3;
  localparam logic [3:0] OP_SUBC = 4'd4;
  localparam logic [3:0] OP_CMP  = 4'd5;
  localparam logic [3:0] OP_DADD = 4'd6;
  localparam logic [3:0] OP_BIT  = 4'd7;
  localparam logic [3:0] OP_BIC  = 4'd8;
  localparam logic [3:0] OP_BIS  = 4'd9;
  localparam logic [3:0] OP_XOR  = 4'd10;
  localparam logic [3:0] OP_AND  = 4'd11;

  logic [ADDR_W-1:0] mask, a, b, bx, res_ar, res_bcd, res_n;
  logic [ADDR_W:0]   sum;
  int                top, ndig;
  logic              cin, sub, cy_ar, v_ar, cy_bcd, wr_n;
  logic              n_f, z_f;
  logic [3:0]        fl_n;
  logic [5:0]        dsum;
  logic              dc;

  always_comb begin
    case (width)
      2'd0:    begin mask = ADDR_W'((1 << BYTE_W) - 1); top = BYTE_W - 1; ndig = BYTE_W / 4; end
      2'd1:    begin mask = ADDR_W'((1 << WORD_W) - 1); top = WORD_W - 1; ndig = WORD_W / 4; end
      default: begin mask = {ADDR_W{1'b1}};             top = ADDR_W - 1; ndig = NDIG;       end
    endcase
  end

  assign a   = src & mask;
  assign b   = dst & mask;
  assign sub = (op == OP_SUB) || (op == OP_SUBC) || (op == OP_CMP);
  assign bx  = sub ? (~a & mask) : a;

  always_comb begin
    case (op)
      OP_ADDC, OP_SUBC: cin = flags_in[0];
      OP_SUB, OP_CMP:   cin = 1'b1;
      default:          cin = 1'b0;
    endcase
  end

  assign sum    = {1'b0, b} + {1'b0, bx} + {{ADDR_W{1'b0}}, cin};
  assign res_ar = sum[ADDR_W-1:0] & mask;
  assign cy_ar  = sum[top+1];
  assign v_ar   = (b[top] == bx[top]) && (res_ar[top] != b[top]);

  always_comb begin
    dc      = flags_in[0];
    cy_bcd  = 1'b0;
    res_bcd = '0;
    for (int i = 0; i < NDIG; i++) begin
      dsum = {2'b00, a[4*i +: 4]} + {2'b00, b[4*i +: 4]} + {5'd0, dc};
      if (dsum > 6'd9) begin
        dsum = dsum + 6'd6;
        dc   = 1'b1;
      end else begin
        dc   = 1'b0;
      end
      res_bcd[4*i +: 4] = dsum[3:0];
      if (i == ndig - 1) cy_bcd = dc;
    end
  end

  always_comb begin
    res_n = '0;
    wr_n  = 1'b1;
    case (op)
      OP_MOV:                          res_n = src & mask;
      OP_ADD, OP_ADDC, OP_SUB, OP_SUBC: res_n = res_ar;
      OP_CMP:                   begin  res_n = res_ar;  wr_n = 1'b0; end
      OP_DADD:                         res_n = res_bcd & mask;
      OP_BIT:                   begin  res_n = a & b;   wr_n = 1'b0; end
      OP_BIC:                          res_n = ~a & b;
      OP_BIS:                          res_n = a | b;
      OP_XOR:                          res_n = a ^ b;
      OP_AND:                          res_n = a & b;
      default:                  begin  res_n = '0;      wr_n = 1'b0; end
    endcase
  end

  assign n_f = res_n[top];
  assign z_f = (res_n == '0);

  always_comb begin
    case (op)
      OP_ADD, OP_ADDC, OP_SUB, OP_SUBC, OP_CMP: fl_n = {v_ar, n_f, z_f, cy_ar};
      OP_DADD:                                  fl_n = {1'b0, n_f, z_f, cy_bcd};
      OP_BIT, OP_AND:                           fl_n = {1'b0, n_f, z_f, ~z_f};
      OP_XOR:                                   fl_n = {a[top] & b[top], n_f, z_f, ~z_f};
      default:                                  fl_n = flags_in;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      wr_en     <= 1'b0;
      result    <= '0;
      flags_out <= '0;
    end else begin
      out_valid <= in_valid;
      wr_en     <= in_valid & wr_n;
      if (in_valid) begin
        result    <= res_n;
        flags_out <= fl_n;
      end
    end
  end

endmodule

// File: rtl/alu2op_checker.sv
module alu2op_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [3:0]  op,
  input logic [1:0]  width,
  input logic [3:0]  flags_in,
  input logic        out_valid,
  input logic [19:0] result,
  input logic        wr_en,
  input logic [3:0]  flags_out
);

  always_comb begin
    if (!rst_n) begin
      p_reset_clear_r1: assert (!out_valid && !wr_en && result == '0 && flags_out == '0);
    end
  end

  p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid));

  p_idle_no_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !wr_en);

  p_byte_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && width == 2'd0 |=> result[19:8] == '0);

  p_word_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && width == 2'd1 |=> result[19:16] == '0);

  p_compare_no_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op == 4'd5 |=> !wr_en);

  p_bcd_v_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op == 4'd6 |=> !flags_out[3]);

  p_logic_v_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (op == 4'd7 || op == 4'd11) |=> !flags_out[3]);

  p_bittest_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op == 4'd7 |=> !wr_en);

  p_logic_carry_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (op == 4'd7 || op == 4'd10 || op == 4'd11) |=> flags_out[0] == !flags_out[1]);

  p_keep_flags_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (op == 4'd0 || op == 4'd8 || op == 4'd9) |=> flags_out == $past(flags_in) && wr_en);

  p_undef_inert_r11: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op >= 4'd12 |=> !wr_en && result == '0 && flags_out == $past(flags_in));

endmodule

bind alu2op alu2op_checker u_alu2op_checker (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .width(width),
  .flags_in(flags_in), .out_valid(out_valid), .result(result),
  .wr_en(wr_en), .flags_out(flags_out)
);

// File: tb/alu2op_bench.sv
module alu2op_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [3:0]  op = '0;
  logic [1:0]  width = '0;
  logic [19:0] src = '0;
  logic [19:0] dst = '0;
  logic [3:0]  flags_in = '0;
  logic        out_valid;
  logic [19:0] result;
  logic        wr_en;
  logic [3:0]  flags_out;

  int checks = 0;
  int errors = 0;

  alu2op u_alu2op (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .width(width),
    .src(src), .dst(dst), .flags_in(flags_in), .out_valid(out_valid),
    .result(result), .wr_en(wr_en), .flags_out(flags_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [19:0] er,
                       input logic ew, input logic [3:0] ef);
    checks++;
    if (out_valid !== 1'b1 || result !== er || wr_en !== ew || flags_out !== ef) begin
      errors++;
      $display("FAIL %s: got valid=%b res=%h wr=%b fl=%b, expected valid=1 res=%h wr=%b fl=%b",
               tag, out_valid, result, wr_en, flags_out, er, ew, ef);
    end
  endtask

  task automatic run(input logic [3:0] o, input logic [1:0] w, input logic [19:0] s,
                     input logic [19:0] d, input logic [3:0] f);
    @(negedge clk);
    in_valid = 1'b1; op = o; width = w; src = s; dst = d; flags_in = f;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset;
    checks++;
    if (out_valid !== 0 || wr_en !== 0 || result !== 0 || flags_out !== 0) begin
      errors++;
      $display("FAIL R1: got valid=%b wr=%b res=%h fl=%b, expected all 0",
               out_valid, wr_en, result, flags_out);
    end
  endtask

  task automatic t_idle;
    @(negedge clk);
    checks++;
    if (out_valid !== 0 || wr_en !== 0) begin
      errors++;
      $display("FAIL R2: got valid=%b wr=%b, expected 0 0", out_valid, wr_en);
    end
  endtask

  task automatic t_add;
    run(4'd1, 2'd0, 20'h0007F, 20'h00001, 4'b0000); check("R4 byte overflow", 20'h00080, 1, 4'b1100);
    run(4'd1, 2'd0, 20'hABCFF, 20'h12301, 4'b0000); check("R3 byte mask wrap", 20'h00000, 1, 4'b0011);
    run(4'd1, 2'd1, 20'h0FFFF, 20'h00001, 4'b0000); check("R4 word carry", 20'h00000, 1, 4'b0011);
    run(4'd1, 2'd2, 20'h7FFFF, 20'h00001, 4'b0000); check("R4 addr overflow", 20'h80000, 1, 4'b1100);
    run(4'd2, 2'd1, 20'h01234, 20'h00001, 4'b0001); check("R4 addc", 20'h01236, 1, 4'b0000);
    run(4'd1, 2'd3, 20'h7FFFF, 20'h00001, 4'b0000); check("R12 width3", 20'h80000, 1, 4'b1100);
  endtask

  task automatic t_sub;
    run(4'd3, 2'd1, 20'h00003, 20'h00005, 4'b0000); check("R5 no borrow", 20'h00002, 1, 4'b0001);
    run(4'd3, 2'd0, 20'h00005, 20'h00003, 4'b0001); check("R5 borrow", 20'h000FE, 1, 4'b0100);
    run(4'd3, 2'd0, 20'h00001, 20'h00080, 4'b0000); check("R5 overflow", 20'h0007F, 1, 4'b1001);
    run(4'd4, 2'd1, 20'h00003, 20'h00005, 4'b0000); check("R5 subc c0", 20'h00001, 1, 4'b0001);
    run(4'd5, 2'd1, 20'h04444, 20'h04444, 4'b0000); check("R6 compare", 20'h00000, 0, 4'b0011);
  endtask

  task automatic t_bcd;
    run(4'd6, 2'd0, 20'h00038, 20'h00045, 4'b1000); check("R7 digit fix", 20'h00083, 1, 4'b0100);
    run(4'd6, 2'd0, 20'h00001, 20'h00099, 4'b0000); check("R7 byte ripple", 20'h00000, 1, 4'b0011);
    run(4'd6, 2'd1, 20'h00001, 20'h00999, 4'b0001); check("R7 word cin", 20'h01001, 1, 4'b0000);
    run(4'd6, 2'd2, 20'h00001, 20'h99999, 4'b0000); check("R7 addr carry", 20'h00000, 1, 4'b0011);
  endtask

  task automatic t_logic;
    run(4'd7, 2'd1, 20'h000F0, 20'h00F00, 4'b1111); check("R8 bit test", 20'h00000, 0, 4'b0010);
    run(4'd11, 2'd0, 20'h0008F, 20'h000F1, 4'b1000); check("R8 and", 20'h00081, 1, 4'b0101);
    run(4'd10, 2'd1, 20'h08000, 20'h08001, 4'b0000); check("R9 xor neg", 20'h00001, 1, 4'b1001);
    run(4'd10, 2'd0, 20'h0000F, 20'h0000F, 4'b1101); check("R9 xor zero", 20'h00000, 1, 4'b0010);
  endtask

  task automatic t_pass;
    run(4'd0, 2'd2, 20'h12345, 20'h00000, 4'b1010); check("R10 mov addr", 20'h12345, 1, 4'b1010);
    run(4'd0, 2'd0, 20'h12345, 20'hFFFFF, 4'b0101); check("R10 mov byte", 20'h00045, 1, 4'b0101);
    run(4'd8, 2'd1, 20'h000FF, 20'h01234, 4'b0101); check("R10 bic", 20'h01200, 1, 4'b0101);
    run(4'd9, 2'd0, 20'h0000F, 20'h000F0, 4'b0000); check("R10 bis", 20'h000FF, 1, 4'b0000);
    run(4'd13, 2'd1, 20'h01111, 20'h02222, 4'b0110); check("R11 undefined", 20'h00000, 0, 4'b0110);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_idle();
    t_add();
    t_sub();
    t_bcd();
    t_logic();
    t_pass();
    t_idle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule